// File: doc/BRIEF.md
# TLB Management Register Front End

This block is the register window through which software maintains a translation table. A small register bus (register select, read/write strobe, write word, registered read word) reaches an index register, a process-identifier register, a zone protection word, a status flag and a search register. Two indirect ports, one for the tag word and one for the data word, read or write the table entry that the index register currently points at. The block holds the table entries itself, so a write through a port lands in storage and a later read returns it.

Writing the search register hands the page number of the written word to an external lookup unit. That unit answers in the same cycle with a hit flag and an entry number. A hit loads the index register with that number; a miss marks the index register as invalid by setting its top bit. Two configuration inputs, the MMU mode and the table access level, decide which registers answer. An access the configuration forbids has no effect and sets a sticky error flag. A one-cycle invalidate output tells downstream translation caches to flush when a tag is rewritten or when the process identifier or zone word changes.

Register select codes: 0 data port, 1 tag port, 2 index, 3 process ID, 4 zone word, 5 search, 6 status.

Top module: `mmu_sreg_front`

## Requirements
- R1: After reset the index, process ID, zone word, error flag, invalidate output and read word are all zero.
- R2: The tag and data ports address the entry chosen by the low bits of the index register (the low log2(ENTRIES) bits of its low byte). A data-port read returns that entry's stored data word on `acc_rdata` in the cycle after the access.
- R3: A tag-port write stores the word and records the current process ID as the entry's owner. A tag-port read returns the stored tag word and loads the process ID register with that entry's owner.
- R4: A data-port write changes only the data word. The entry's tag and owner are left as they were.
- R5: A search write drives `lk_req` high and `lk_vaddr` with the written word's bits 9..0 cleared, in the same cycle. On `lk_hit` the index register becomes `lk_idx` zero-extended.
- R6: A search miss sets bit 31 of the index register and leaves bits 30..0 unchanged.
- R7: With `cfg_mode` below 2 or `cfg_level` equal to 0, every read returns zero and every write is ignored.
- R8: Reads of the data port, tag port, process ID and zone word need bit 0 of `cfg_level`. Without it they return zero. Reads of the index register are not subject to this bit.
- R9: Writes to the process ID, zone word and search register need `cfg_level` of 2 or more. Writes to the index, tag and data ports and to status need only the block to be enabled.
- R10: `inval_o` is high for exactly the cycle after a permitted tag-port write, a zone write with a new value, or a process ID write with a new low byte. A rewrite with the same value and a data-port write give no pulse.
- R11: A forbidden access sets `err_o`. It stays set until a permitted status write clears it. A status read returns the flag in bit 0.
- R12: The process ID register holds the low 8 bits of the written word, shown on `pid_o`. The zone word is shown on `zpr_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_en | input | 1 | Register access strobe |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_sel | input | 3 | Register select code |
| acc_wdata | input | 32 | Write word |
| acc_rdata | output | 32 | Read word, valid the cycle after a read |
| cfg_mode | input | 2 | MMU mode; below 2 disables the block |
| cfg_level | input | 2 | Table access level |
| lk_req | output | 1 | Search request to the lookup unit |
| lk_vaddr | output | 32 | Page-aligned address to look up |
| lk_hit | input | 1 | Lookup hit, same cycle as `lk_req` |
| lk_idx | input | 8 | Matching entry number |
| pid_o | output | 8 | Current process ID |
| zpr_o | output | 32 | Current zone protection word |
| inval_o | output | 1 | One-cycle invalidate pulse |
| err_o | output | 1 | Sticky forbidden-access flag |

## Verification
A corrupted index register shows up as a wrong word on the very next data or tag read, because both ports decode it directly. It also shows up through the miss bit when the index register is read back. A wrong owner field stays hidden until a tag read copies it into the process ID, and it then appears on `pid_o` one cycle later. Stale zone or process ID state is visible on `zpr_o` and `pid_o` in the cycle after the write. A missing or doubled invalidate appears on `inval_o` in that same cycle. A lost or stuck error flag appears on `err_o` at once, and on the status read one cycle after that read.

// File: rtl/mmu_sreg_pkg.sv
package mmu_sreg_pkg;

    localparam int WORD_W  = 32;
    localparam int OWNER_W = 8;
    localparam int PAGE_LSB = 10;

    typedef enum logic [2:0] {
        SEL_DATA = 3'd0,
        SEL_TAG  = 3'd1,
        SEL_IDX  = 3'd2,
        SEL_PID  = 3'd3,
        SEL_ZONE = 3'd4,
        SEL_SRCH = 3'd5,
        SEL_STAT = 3'd6,
        SEL_NONE = 3'd7
    } sreg_sel_e;

    typedef struct packed {
        logic [WORD_W-1:0]  idx;
        logic [OWNER_W-1:0] pid;
        logic [WORD_W-1:0]  zpr;
        logic [WORD_W-1:0]  rdata;
        logic               err;
        logic               inval;
    } front_st_t;

endpackage

// File: rtl/mmu_sreg_gate.sv
module mmu_sreg_gate
    import mmu_sreg_pkg::*;
(
    input  logic       req,
    input  logic       wr,
    input  logic [2:0] sel,
    input  logic [1:0] mode,
    input  logic [1:0] level,
    output logic       ok,
    output logic       bad
);
    logic disabled;
    logic perm;
    logic rd_right;
    logic wr_right;

    assign disabled = (mode < 2'd2) || (level == 2'd0);
    assign rd_right = level[0];
    assign wr_right = (level >= 2'd2);

    always_comb begin
        case (sreg_sel_e'(sel))
            SEL_DATA, SEL_TAG:  perm = wr ? 1'b1 : rd_right;
            SEL_PID, SEL_ZONE:  perm = wr ? wr_right : rd_right;
            SEL_SRCH:           perm = wr ? wr_right : 1'b1;
            default:            perm = 1'b1;
        endcase
    end

    assign ok  = req && !disabled && perm;
    assign bad = req && !ok;
endmodule

// File: rtl/mmu_sreg_table.sv
module mmu_sreg_table
    import mmu_sreg_pkg::*;
#(
    parameter int ENTRIES = 64,
    localparam int AW = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we_tag,
    input  logic               we_data,
    input  logic [AW-1:0]      addr,
    input  logic [WORD_W-1:0]  wword,
    input  logic [OWNER_W-1:0] wowner,
    output logic [WORD_W-1:0]  rtag,
    output logic [WORD_W-1:0]  rdat,
    output logic [OWNER_W-1:0] rowner
);
    logic [WORD_W-1:0]  tag_w   [ENTRIES];
    logic [WORD_W-1:0]  dat_w   [ENTRIES];
    logic [OWNER_W-1:0] owner_w [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        logic               sel_hit;
        logic [WORD_W-1:0]  tag_q;
        logic [WORD_W-1:0]  dat_q;
        logic [OWNER_W-1:0] own_q;

        assign sel_hit = (addr == AW'(g));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tag_q <= '0;
                dat_q <= '0;
                own_q <= '0;
            end else begin
                if (we_tag && sel_hit) begin
                    tag_q <= wword;
                    own_q <= wowner;
                end
                if (we_data && sel_hit) begin
                    dat_q <= wword;
                end
            end
        end

        assign tag_w[g]   = tag_q;
        assign dat_w[g]   = dat_q;
        assign owner_w[g] = own_q;
    end

    assign rtag   = tag_w[addr];
    assign rdat   = dat_w[addr];
    assign rowner = owner_w[addr];
endmodule

// File: rtl/mmu_sreg_front.sv
module mmu_sreg_front
    import mmu_sreg_pkg::*;
#(
    parameter int ENTRIES = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acc_en,
    input  logic               acc_wr,
    input  logic [2:0]         acc_sel,
    input  logic [WORD_W-1:0]  acc_wdata,
    output logic [WORD_W-1:0]  acc_rdata,
    input  logic [1:0]         cfg_mode,
    input  logic [1:0]         cfg_level,
    output logic               lk_req,
    output logic [WORD_W-1:0]  lk_vaddr,
    input  logic               lk_hit,
    input  logic [7:0]         lk_idx,
    output logic [OWNER_W-1:0] pid_o,
    output logic [WORD_W-1:0]  zpr_o,
    output logic               inval_o,
    output logic               err_o
);
    localparam int AW = $clog2(ENTRIES);

    front_st_t st_d, st_q;

    logic               acc_ok;
    logic               acc_bad;
    logic               t_we_tag;
    logic               t_we_data;
    logic [AW-1:0]      t_addr;
    logic [WORD_W-1:0]  t_tag;
    logic [WORD_W-1:0]  t_dat;
    logic [OWNER_W-1:0] t_owner;
    logic [WORD_W-1:0]  idx_w;

    mmu_sreg_gate u_gate (
        .req   (acc_en),
        .wr    (acc_wr),
        .sel   (acc_sel),
        .mode  (cfg_mode),
        .level (cfg_level),
        .ok    (acc_ok),
        .bad   (acc_bad)
    );

    assign t_addr = st_q.idx[AW-1:0];

    mmu_sreg_table #(.ENTRIES(ENTRIES)) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_tag  (t_we_tag),
        .we_data (t_we_data),
        .addr    (t_addr),
        .wword   (acc_wdata),
        .wowner  (st_q.pid),
        .rtag    (t_tag),
        .rdat    (t_dat),
        .rowner  (t_owner)
    );

    assign lk_req   = acc_ok && acc_wr && (acc_sel == SEL_SRCH);
    assign lk_vaddr = {acc_wdata[WORD_W-1:PAGE_LSB], {PAGE_LSB{1'b0}}};

    always_comb begin
        st_d       = st_q;
        st_d.inval = 1'b0;
        t_we_tag   = 1'b0;
        t_we_data  = 1'b0;

        if (acc_bad) begin
            st_d.err = 1'b1;
            if (!acc_wr) begin
                st_d.rdata = '0;
            end
        end else if (acc_ok) begin
            if (!acc_wr) begin
                case (sreg_sel_e'(acc_sel))
                    SEL_DATA: st_d.rdata = t_dat;
                    SEL_TAG: begin
                        st_d.rdata = t_tag;
                        st_d.pid   = t_owner;
                    end
                    SEL_IDX:  st_d.rdata = st_q.idx;
                    SEL_PID:  st_d.rdata = {{(WORD_W-OWNER_W){1'b0}}, st_q.pid};
                    SEL_ZONE: st_d.rdata = st_q.zpr;
                    SEL_STAT: st_d.rdata = {{(WORD_W-1){1'b0}}, st_q.err};
                    default:  st_d.rdata = '0;
                endcase
            end else begin
                case (sreg_sel_e'(acc_sel))
                    SEL_DATA: t_we_data = 1'b1;
                    SEL_TAG: begin
                        t_we_tag   = 1'b1;
                        st_d.inval = 1'b1;
                    end
                    SEL_IDX: st_d.idx = acc_wdata;
                    SEL_PID: begin
                        if (acc_wdata[OWNER_W-1:0] != st_q.pid) begin
                            st_d.pid   = acc_wdata[OWNER_W-1:0];
                            st_d.inval = 1'b1;
                        end
                    end
                    SEL_ZONE: begin
                        if (acc_wdata != st_q.zpr) begin
                            st_d.zpr   = acc_wdata;
                            st_d.inval = 1'b1;
                        end
                    end
                    SEL_SRCH: begin
                        if (lk_hit) begin
                            st_d.idx = {{(WORD_W-8){1'b0}}, lk_idx};
                        end else begin
                            st_d.idx[WORD_W-1] = 1'b1;
                        end
                    end
                    SEL_STAT: st_d.err = 1'b0;
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign idx_w     = st_q.idx;
    assign acc_rdata = st_q.rdata;
    assign pid_o     = st_q.pid;
    assign zpr_o     = st_q.zpr;
    assign inval_o   = st_q.inval;
    assign err_o     = st_q.err;
endmodule

// File: rtl/mmu_sreg_front_chk.sv
module mmu_sreg_front_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        acc_en,
    input logic        acc_wr,
    input logic [2:0]  acc_sel,
    input logic [31:0] acc_wdata,
    input logic [31:0] acc_rdata,
    input logic [1:0]  cfg_mode,
    input logic [1:0]  cfg_level,
    input logic        lk_hit,
    input logic [7:0]  lk_idx,
    input logic [7:0]  pid_o,
    input logic [31:0] zpr_o,
    input logic        inval_o,
    input logic        err_o,
    input logic [31:0] idx_w
);
    logic off;
    logic srch_wr;
    assign off     = (cfg_mode < 2'd2) || (cfg_level == 2'd0);
    assign srch_wr = acc_en && acc_wr && (acc_sel == 3'd5) && !off && (cfg_level >= 2'd2);

    p_gated_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        acc_en && off |=> $stable(pid_o) && $stable(zpr_o) && $stable(idx_w));

    p_gated_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        acc_en && !acc_wr && off |=> acc_rdata == 32'd0);

    p_hit_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        srch_wr && lk_hit |=> idx_w == {24'd0, $past(lk_idx)});

    p_miss_mark_r6: assert property (@(posedge clk) disable iff (!rst_n)
        srch_wr && !lk_hit |=> idx_w[31] && (idx_w[30:0] == $past(idx_w[30:0])));

    p_zone_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        acc_en && acc_wr && (acc_sel == 3'd4) && (cfg_level < 2'd2) |=> $stable(zpr_o));

    p_inval_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        inval_o |-> $past(acc_en && acc_wr));

    p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        err_o && !(acc_en && acc_wr && (acc_sel == 3'd6)) |=> err_o);

    // R11: the error flag only rises after an access
    p_err_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> $past(acc_en));
endmodule

bind mmu_sreg_front mmu_sreg_front_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_en    (acc_en),
    .acc_wr    (acc_wr),
    .acc_sel   (acc_sel),
    .acc_wdata (acc_wdata),
    .acc_rdata (acc_rdata),
    .cfg_mode  (cfg_mode),
    .cfg_level (cfg_level),
    .lk_hit    (lk_hit),
    .lk_idx    (lk_idx),
    .pid_o     (pid_o),
    .zpr_o     (zpr_o),
    .inval_o   (inval_o),
    .err_o     (err_o),
    .idx_w     (idx_w)
);

// File: tb/mmu_sreg_front_test.sv
module mmu_sreg_front_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_en = 1'b0;
    logic        acc_wr = 1'b0;
    logic [2:0]  acc_sel = 3'd0;
    logic [31:0] acc_wdata = 32'd0;
    logic [31:0] acc_rdata;
    logic [1:0]  cfg_mode = 2'd2;
    logic [1:0]  cfg_level = 2'd3;
    logic        lk_req;
    logic [31:0] lk_vaddr;
    logic        lk_hit = 1'b0;
    logic [7:0]  lk_idx = 8'd0;
    logic [7:0]  pid_o;
    logic [31:0] zpr_o;
    logic        inval_o;
    logic        err_o;

    localparam logic [2:0] S_DATA = 3'd0, S_TAG = 3'd1, S_IDX = 3'd2, S_PID = 3'd3,
                           S_ZONE = 3'd4, S_SRCH = 3'd5, S_STAT = 3'd6;
    localparam int K_RD = 0, K_PID = 1, K_ZPR = 2, K_INV = 3, K_ERR = 4;

    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       req;
    } sb_item_t;

    sb_item_t sb[$];
    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    mmu_sreg_front uut (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
        .acc_sel(acc_sel), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .cfg_mode(cfg_mode), .cfg_level(cfg_level), .lk_req(lk_req),
        .lk_vaddr(lk_vaddr), .lk_hit(lk_hit), .lk_idx(lk_idx), .pid_o(pid_o),
        .zpr_o(zpr_o), .inval_o(inval_o), .err_o(err_o)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic expect_v(int kind, logic [31:0] exp, string req);
        sb_item_t it;
        it.kind = kind;
        it.exp  = exp;
        it.req  = req;
        sb.push_back(it);
    endtask

    task automatic op(logic wr, logic [2:0] sel, logic [31:0] d);
        @(negedge clk);
        acc_en = 1'b1;
        acc_wr = wr;
        acc_sel = sel;
        acc_wdata = d;
    endtask

    task automatic idle();
        @(negedge clk);
        acc_en = 1'b0;
        acc_wr = 1'b0;
    endtask

    task automatic set_cfg(logic [1:0] m, logic [1:0] l);
        @(negedge clk);
        acc_en = 1'b0;
        cfg_mode = m;
        cfg_level = l;
    endtask

    // monitor: compares queued expectations shortly after the edge that produced them
    initial begin
        forever begin
            @(posedge clk);
            #5;
            while (sb.size() > 0) begin
                sb_item_t it;
                logic [31:0] act;
                it = sb.pop_front();
                case (it.kind)
                    K_RD:    act = acc_rdata;
                    K_PID:   act = {24'd0, pid_o};
                    K_ZPR:   act = zpr_o;
                    K_INV:   act = {31'd0, inval_o};
                    default: act = {31'd0, err_o};
                endcase
                check(it.req, act, it.exp);
            end
        end
    end

    initial begin
        #(20 * 20000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 rdata", acc_rdata, 0);
        check("R1 pid", {24'd0, pid_o}, 0);
        check("R1 zpr", zpr_o, 0);
        check("R1 err", {31'd0, err_o}, 0);
        check("R1 inval", {31'd0, inval_o}, 0);
        op(0, S_IDX, 0);           expect_v(K_RD, 0, "R1 index");

        op(1, S_IDX, 5);
        op(1, S_PID, 32'h3C);      expect_v(K_INV, 1, "R10 pid change"); expect_v(K_PID, 32'h3C, "R12 pid");
        idle();                    expect_v(K_INV, 0, "R10 single pulse");
        op(1, S_PID, 32'h13C);     expect_v(K_PID, 32'h3C, "R12 low byte"); expect_v(K_INV, 0, "R10 same pid");
        op(1, S_TAG, 32'hABCD0040); expect_v(K_INV, 1, "R10 tag write");
        op(1, S_DATA, 32'h12345678); expect_v(K_INV, 0, "R10 data write");
        op(1, S_PID, 32'h07);      expect_v(K_PID, 32'h07, "R12 pid");
        op(0, S_TAG, 0);           expect_v(K_RD, 32'hABCD0040, "R3 tag read"); expect_v(K_PID, 32'h3C, "R3 owner to pid");
        op(0, S_DATA, 0);          expect_v(K_RD, 32'h12345678, "R2 data read");

        op(1, S_IDX, 6);
        op(1, S_DATA, 32'hCAFEF00D);
        op(0, S_TAG, 0);           expect_v(K_RD, 0, "R4 tag untouched"); expect_v(K_PID, 0, "R4 owner untouched");
        op(0, S_DATA, 0);          expect_v(K_RD, 32'hCAFEF00D, "R2 entry 6");
        op(1, S_IDX, 5);
        op(0, S_DATA, 0);          expect_v(K_RD, 32'h12345678, "R2 entry 5");
        op(0, S_TAG, 0);           expect_v(K_PID, 32'h3C, "R3 owner reload");

        op(1, S_ZONE, 32'hF0F0);   expect_v(K_INV, 1, "R10 zone change"); expect_v(K_ZPR, 32'hF0F0, "R12 zone");
        op(1, S_ZONE, 32'hF0F0);   expect_v(K_INV, 0, "R10 same zone");
        op(0, S_ZONE, 0);          expect_v(K_RD, 32'hF0F0, "R8 zone read");

        lk_hit = 1'b1; lk_idx = 8'h2A;
        op(1, S_SRCH, 32'h12345FFF);
        #1;
        check("R5 lk_req", {31'd0, lk_req}, 1);
        check("R5 lk_vaddr", lk_vaddr, 32'h12345C00);
        op(0, S_IDX, 0);           expect_v(K_RD, 32'h2A, "R5 hit index");
        lk_hit = 1'b0;
        op(1, S_SRCH, 32'h0);
        op(0, S_IDX, 0);           expect_v(K_RD, 32'h8000002A, "R6 miss bit"); expect_v(K_ERR, 0, "R11 no error");

        set_cfg(2, 1);
        op(1, S_PID, 32'h55);      expect_v(K_PID, 32'h3C, "R9 pid locked"); expect_v(K_ERR, 1, "R11 error set");
        op(0, S_STAT, 0);          expect_v(K_RD, 1, "R11 status read");
        op(1, S_STAT, 0);          expect_v(K_ERR, 0, "R11 status clear");
        op(0, S_PID, 0);           expect_v(K_RD, 32'h3C, "R8 pid read level1");
        op(1, S_ZONE, 32'h1234);   expect_v(K_ZPR, 32'hF0F0, "R9 zone locked");
        lk_hit = 1'b1; lk_idx = 8'h07;
        op(1, S_SRCH, 32'h0);
        #1;
        check("R9 search blocked", {31'd0, lk_req}, 0);
        op(0, S_IDX, 0);           expect_v(K_RD, 32'h8000002A, "R9 index unchanged");
        op(1, S_IDX, 3);
        op(1, S_TAG, 32'h11110000); expect_v(K_INV, 1, "R9 tag write level1");
        op(0, S_TAG, 0);           expect_v(K_RD, 32'h11110000, "R3 tag entry 3"); expect_v(K_PID, 32'h3C, "R3 owner entry 3");

        set_cfg(2, 2);
        op(1, S_IDX, 5);
        op(0, S_DATA, 0);          expect_v(K_RD, 0, "R8 data read denied"); expect_v(K_ERR, 1, "R11 read denied");
        op(0, S_IDX, 0);           expect_v(K_RD, 5, "R8 index read level2");
        op(1, S_PID, 32'h21);      expect_v(K_PID, 32'h21, "R9 pid write level2");

        set_cfg(1, 3);
        op(0, S_IDX, 0);           expect_v(K_RD, 0, "R7 mode read zero");
        op(1, S_IDX, 9);
        set_cfg(2, 3);
        op(0, S_IDX, 0);           expect_v(K_RD, 5, "R7 mode write ignored");
        set_cfg(2, 0);
        op(1, S_ZONE, 32'h0);      expect_v(K_ZPR, 32'hF0F0, "R7 level0 write ignored");
        op(0, S_ZONE, 0);          expect_v(K_RD, 0, "R7 level0 read zero");
        set_cfg(2, 3);
        op(0, S_ZONE, 0);          expect_v(K_RD, 32'hF0F0, "R7 zone kept");
        idle();
        idle();
        idle();

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule